// File: doc/BRIEF.md
# Dual-Rail Completion Handshake Stage

This block controls one stage of a self-timed pipeline inside a clocked design. It answers a four-phase request/acknowledge handshake from the previous stage, starts its own datapath, waits until the datapath reports completion, stores the result and then offers it to the next stage with a second request/acknowledge pair.

Completion can be detected in two ways, chosen per transaction. In dual-rail mode every result bit arrives on a pair of wires, a high rail and a low rail. The stage finishes only when every pair carries a valid code. A pair with both wires high is a fault, which the stage reports and never accepts. In matched-delay mode the result is trusted a fixed, parameterised number of cycles after start. Only the high rail is used as plain data in this mode. Between two dual-rail computations the datapath must return every pair to the empty code before the next start.

Top module: `completion_stage`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `start`, `ack_in`, `req_out`, `err` and `data_out` are all 0.
- R2: Every input passes through one register. `start` rises at the second rising edge after `req_in` goes high while the stage is idle. No `start` is issued without a sampled request.
- R3: A pair {hi,lo} encodes 00 = empty, 01 = valid 0, 10 = valid 1. In dual-rail mode, `ack_in` and `req_out` stay low while any pair is not valid. They rise at the second edge after the last pair becomes valid, and at that edge `data_out[i]` takes the value of `rail_hi[i]`.
- R4: A pair of 11 seen during a dual-rail computation sets `err`. `err` stays high until reset, and the stage never acknowledges that computation.
- R5: In matched-delay mode (`mode` = 1), `ack_in` rises exactly DELAY+1 edges after `start` rises. `data_out` captures `rail_hi`, and `rail_lo` is ignored, so no `err` is raised.
- R6: `req_out` falls two edges after `ack_out` goes high, and `ack_in` falls two edges after `req_in` goes low. The stage returns to idle only once both are low and `ack_out` is low.
- R7: In dual-rail mode a new `start` waits until every pair has been sampled at 00.
- R8: `mode` is latched when `start` is issued. A change of `mode` during a transaction has no effect on it.
- R9: `data_out` changes only at the edge where `ack_in` rises and holds its value otherwise.
- R10: `start` falls at the edge where `ack_in` rises, so the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 1 | Request from the previous stage |
| ack_in | output | 1 | Acknowledge to the previous stage |
| start | output | 1 | Start command to this stage's datapath |
| mode | input | 1 | 0 = dual-rail completion, 1 = matched delay |
| rail_hi | input | WIDTH | High rail of each result pair |
| rail_lo | input | WIDTH | Low rail of each result pair |
| req_out | output | 1 | Request to the next stage |
| ack_out | input | 1 | Acknowledge from the next stage |
| data_out | output | WIDTH | Captured result |
| err | output | 1 | Sticky illegal-code flag |

## Verification
Dual-rail transactions are run with all bits resolving in one cycle and with each bit pair resolving at its own random cycle up to six cycles late. This separates a stage that waits for the slowest bit from one that fires early, and the all-zero and all-one values expose a swapped rail decode. Matched-delay transactions measure the exact start-to-acknowledge distance, both with and without a mode flip part-way through, while the low rail is held at all ones to show it is ignored. A spacer-violation run holds valid codes after a capture and shows the next start is held back. An injected 11 pair shows the error is sticky and blocks acknowledge until reset.

// File: rtl/stage_pkg.sv
package stage_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } stage_st_t;

  // pair code written as {hi, lo}
  typedef enum logic [1:0] {
    PC_EMPTY = 2'b00,
    PC_ZERO  = 2'b01,
    PC_ONE   = 2'b10,
    PC_BAD   = 2'b11
  } pair_code_t;

  localparam logic MODE_DUAL  = 1'b0;
  localparam logic MODE_DELAY = 1'b1;

  function automatic pair_code_t classify(input logic hi, input logic lo);
    return pair_code_t'({hi, lo});
  endfunction

endpackage

// File: rtl/dr_detect.sv
module dr_detect
  import stage_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_en,
  input  logic [WIDTH-1:0] rail_hi,
  input  logic [WIDTH-1:0] rail_lo,
  output logic [WIDTH-1:0] val_bits,
  output logic             all_valid,
  output logic             all_spacer,
  output logic             err
);

  logic [WIDTH-1:0] hi_q;
  logic [WIDTH-1:0] lo_q;
  logic [WIDTH-1:0] pair_ok;
  logic [WIDTH-1:0] pair_empty;
  logic [WIDTH-1:0] pair_bad;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= rail_hi;
      lo_q <= rail_lo;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pair
    pair_code_t code;
    assign code          = classify(hi_q[i], lo_q[i]);
    assign pair_ok[i]    = (code == PC_ZERO) || (code == PC_ONE);
    assign pair_empty[i] = (code == PC_EMPTY);
    assign pair_bad[i]   = (code == PC_BAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (chk_en && (|pair_bad)) begin
      err_q <= 1'b1;
    end
  end

  assign val_bits   = hi_q;
  assign all_valid  = &pair_ok;
  assign all_spacer = &pair_empty;
  assign err        = err_q;

endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
  parameter int DELAY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      if (!run) begin
        cnt <= '0;
      end else if (cnt != CW'(DELAY)) begin
        cnt <= cnt + CW'(1);
      end
      done_q <= run && (cnt == CW'(DELAY - 1));
    end
  end

  assign done = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_DONE_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(run)); // R5

endmodule

// File: rtl/stage_ctrl.sv
module stage_ctrl
  import stage_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_in,
  input  logic             ack_out,
  input  logic             mode,
  input  logic             dr_valid,
  input  logic             dr_spacer,
  input  logic             dr_err,
  input  logic             tmr_done,
  input  logic [WIDTH-1:0] cap_bits,
  output logic             chk_en,
  output logic             start,
  output logic             ack_in,
  output logic             req_out,
  output logic [WIDTH-1:0] data_out
);

  stage_st_t        state;
  logic             s_req;
  logic             s_ack;
  logic             s_mode;
  logic             mode_q;
  logic             start_q;
  logic             ack_q;
  logic             reqo_q;
  logic [WIDTH-1:0] data_q;
  logic             finish;
  logic             go;
  logic             ack_nx;
  logic             reqo_nx;

  assign go      = s_req && ((s_mode == MODE_DELAY) || dr_spacer);
  assign finish  = (mode_q == MODE_DELAY) ? tmr_done : (dr_valid && !dr_err);
  assign ack_nx  = ack_q && s_req;
  assign reqo_nx = reqo_q && !s_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_req   <= 1'b0;
      s_ack   <= 1'b0;
      s_mode  <= MODE_DUAL;
      mode_q  <= MODE_DUAL;
      state   <= ST_IDLE;
      start_q <= 1'b0;
      ack_q   <= 1'b0;
      reqo_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      s_req  <= req_in;
      s_ack  <= ack_out;
      s_mode <= mode;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            state   <= ST_RUN;
            start_q <= 1'b1;
            mode_q  <= s_mode;
          end
        end
        ST_RUN: begin
          if (finish) begin
            state   <= ST_HOLD;
            start_q <= 1'b0;
            ack_q   <= 1'b1;
            reqo_q  <= 1'b1;
            data_q  <= cap_bits;
          end
        end
        ST_HOLD: begin
          ack_q  <= ack_nx;
          reqo_q <= reqo_nx;
          if (!ack_nx && !reqo_nx && !s_ack) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign chk_en   = (state == ST_RUN) && (mode_q == MODE_DUAL);
  assign start    = start_q;
  assign ack_in   = ack_q;
  assign req_out  = reqo_q;
  assign data_out = data_q;

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(start_q) |-> $past(s_req)); // R2

  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past((mode_q == MODE_DELAY) ? tmr_done : (dr_valid && !dr_err))); // R3

  AST_NO_ACK_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    (dr_err && (state == ST_RUN)) |=> !ack_q); // R4

  AST_SPACER_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($rose(start_q) && (mode_q == MODE_DUAL)) |-> $past(dr_spacer)); // R7

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$rose(ack_q) |-> $stable(data_q)); // R9

  AST_NO_START_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    !(start_q && ack_q)); // R10

endmodule

// File: rtl/completion_stage.sv
module completion_stage #(
  parameter int WIDTH = 8,
  parameter int DELAY = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_in,
  output logic             ack_in,
  output logic             start,
  input  logic             mode,
  input  logic [WIDTH-1:0] rail_hi,
  input  logic [WIDTH-1:0] rail_lo,
  output logic             req_out,
  input  logic             ack_out,
  output logic [WIDTH-1:0] data_out,
  output logic             err
);

  logic [WIDTH-1:0] val_bits;
  logic             all_valid;
  logic             all_spacer;
  logic             dr_err;
  logic             chk_en;
  logic             tmr_done;

  dr_detect #(.WIDTH(WIDTH)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .chk_en    (chk_en),
    .rail_hi   (rail_hi),
    .rail_lo   (rail_lo),
    .val_bits  (val_bits),
    .all_valid (all_valid),
    .all_spacer(all_spacer),
    .err       (dr_err)
  );

  delay_timer #(.DELAY(DELAY)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (start),
    .done(tmr_done)
  );

  stage_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_in   (req_in),
    .ack_out  (ack_out),
    .mode     (mode),
    .dr_valid (all_valid),
    .dr_spacer(all_spacer),
    .dr_err   (dr_err),
    .tmr_done (tmr_done),
    .cap_bits (val_bits),
    .chk_en   (chk_en),
    .start    (start),
    .ack_in   (ack_in),
    .req_out  (req_out),
    .data_out (data_out)
  );

  assign err = dr_err;

endmodule

// File: tb/test_completion_stage.sv
module test_completion_stage;

  localparam int W        = 8;
  localparam int DELAY    = 5;
  localparam int CLK_HALF = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_in = 1'b0;
  logic         ack_out = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] rail_hi = '0;
  logic [W-1:0] rail_lo = '0;
  logic         ack_in, start, req_out, err;
  logic [W-1:0] data_out;

  int vectors = 0;
  int miscompares = 0;

  completion_stage #(.WIDTH(W), .DELAY(DELAY)) i_completion_stage (
    .clk(clk), .rst(rst), .req_in(req_in), .ack_in(ack_in), .start(start),
    .mode(mode), .rail_hi(rail_hi), .rail_lo(rail_lo), .req_out(req_out),
    .ack_out(ack_out), .data_out(data_out), .err(err)
  );

  always #(CLK_HALF) clk = ~clk;

  // reference model: behavioural, updated on each rising edge
  int           m_phase;
  logic         m_start, m_ack, m_reqo, m_err, m_mode;
  logic [W-1:0] m_data;
  int           m_cnt;
  logic         p_req, p_ack, p_mode;
  logic [W-1:0] p_hi, p_lo;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_start = 0; m_ack = 0; m_reqo = 0; m_err = 0;
      m_mode = 0; m_data = '0; m_cnt = 0;
      p_req = 0; p_ack = 0; p_mode = 0; p_hi = '0; p_lo = '0;
    end else begin
      logic done_now;
      logic nack, nreq;
      done_now = 1'b0;
      if (m_phase == 0) begin
        if (p_req && (p_mode || ((p_hi | p_lo) == '0))) begin
          m_phase = 1; m_start = 1; m_mode = p_mode; m_cnt = 0;
        end
      end else if (m_phase == 1) begin
        if (m_mode) begin
          if (m_cnt == DELAY) done_now = 1'b1;
          else m_cnt = m_cnt + 1;
        end else begin
          if ((p_hi & p_lo) != '0) m_err = 1;
          if ((p_hi ^ p_lo) == '1 && !m_err) done_now = 1'b1;
        end
        if (done_now) begin
          m_phase = 2; m_start = 0; m_ack = 1; m_reqo = 1; m_data = p_hi;
        end
      end else begin
        nack = m_ack && p_req;
        nreq = m_reqo && !p_ack;
        m_ack = nack; m_reqo = nreq;
        if (!nack && !nreq && !p_ack) m_phase = 0;
      end
      p_req = req_in; p_ack = ack_out; p_mode = mode; p_hi = rail_hi; p_lo = rail_lo;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R2", "start vs model", 32'(start), 32'(m_start));
    chk("R3", "ack_in vs model", 32'(ack_in), 32'(m_ack));
    chk("R6", "req_out vs model", 32'(req_out), 32'(m_reqo));
    chk("R4", "err vs model", 32'(err), 32'(m_err));
    chk("R9", "data_out vs model", 32'(data_out), 32'(m_data));
    chk("R10", "start with ack", 32'(start && ack_in), 32'd0);
  endtask

  task automatic finish_hs(input logic clear_rails);
    int n;
    ack_out = 1'b1;
    n = 0;
    while (req_out !== 1'b0 && n < 64) begin step(); n++; end
    chk("R6", "edges ack_out to req_out low", n, 2);
    ack_out = 1'b0;
    req_in  = 1'b0;
    if (clear_rails) begin rail_hi = '0; rail_lo = '0; end
    n = 0;
    while (ack_in !== 1'b0 && n < 64) begin step(); n++; end
    chk("R6", "edges req_in low to ack_in low", n, 2);
    step(); step();
  endtask

  task automatic dual_txn(input logic [W-1:0] val, input int maxlag);
    int n;
    int lag [W];
    mode = 1'b0; rail_hi = '0; rail_lo = '0; req_in = 1'b1;
    n = 0;
    while (start !== 1'b1 && n < 64) begin step(); n++; end
    chk("R2", "edges req_in to start", n, 2);
    for (int i = 0; i < W; i++) lag[i] = int'($urandom_range(maxlag, 0));
    for (int t = 0; t <= maxlag; t++) begin
      int rem;
      rem = 0;
      for (int i = 0; i < W; i++) begin
        if (lag[i] == t) begin rail_hi[i] = val[i]; rail_lo[i] = ~val[i]; end
        if (lag[i] > t) rem++;
      end
      step();
      if (rem > 0) chk("R3", "ack before completion", 32'(ack_in), 32'd0);
    end
    n = 0;
    while (ack_in !== 1'b1 && n < 64) begin step(); n++; end
    chk("R3", "captured value", 32'(data_out), 32'(val));
    finish_hs(1'b1);
    chk("R9", "data held after handshake", 32'(data_out), 32'(val));
  endtask

  task automatic delay_txn(input logic [W-1:0] val, input logic flip);
    int n;
    mode = 1'b1; rail_hi = val; rail_lo = '1; req_in = 1'b1;
    n = 0;
    while (start !== 1'b1 && n < 64) begin step(); n++; end
    if (flip) begin mode = 1'b0; rail_hi = '0; rail_lo = '0; end
    n = 0;
    while (ack_in !== 1'b1 && n < 64) begin step(); n++; end
    chk(flip ? "R8" : "R5", "edges start to ack_in", n, DELAY + 1);
    chk("R5", "delay-mode data", 32'(data_out), flip ? 32'd0 : 32'(val));
    chk("R5", "low rail ignored, no err", 32'(err), 32'd0);
    finish_hs(1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {27'd0, start, ack_in, req_out, err, 1'b0}, 32'd0);
    chk("R1", "data in reset", 32'(data_out), 32'd0);
    rst = 1'b0;
    step();
    chk("R1", "outputs after reset", {27'd0, start, ack_in, req_out, err, |data_out}, 32'd0);

    dual_txn(8'hA5, 0);
    dual_txn(8'h00, 3);
    dual_txn(8'hFF, 3);
    for (int k = 0; k < 10; k++) dual_txn(W'($urandom), k % 7);

    delay_txn(8'h3C, 1'b0);
    delay_txn(8'hC3, 1'b1);
    dual_txn(8'h81, 6);

    // R7: rails left valid after capture hold back the next start
    mode = 1'b0; req_in = 1'b1; rail_hi = '0; rail_lo = '0;
    n = 0;
    while (start !== 1'b1 && n < 64) begin step(); n++; end
    rail_hi = 8'h5A; rail_lo = 8'hA5;
    n = 0;
    while (ack_in !== 1'b1 && n < 64) begin step(); n++; end
    chk("R3", "value before spacer test", 32'(data_out), 32'h5A);
    finish_hs(1'b0);
    req_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R7", "start held without spacer", 32'(start), 32'd0);
    end
    rail_hi = '0; rail_lo = '0;
    n = 0;
    while (start !== 1'b1 && n < 64) begin step(); n++; end
    chk("R7", "edges spacer to start", n, 2);
    rail_hi = 8'h5A; rail_lo = 8'hA5;
    n = 0;
    while (ack_in !== 1'b1 && n < 64) begin step(); n++; end
    finish_hs(1'b1);

    // R4: illegal pair
    mode = 1'b0; req_in = 1'b1;
    n = 0;
    while (start !== 1'b1 && n < 64) begin step(); n++; end
    rail_hi = 8'h0F; rail_lo = 8'hF1;
    repeat (3) step();
    chk("R4", "err raised on 11", 32'(err), 32'd1);
    chk("R4", "no ack on 11", 32'(ack_in), 32'd0);
    rail_lo = 8'hF0;
    repeat (5) step();
    chk("R4", "err sticky", 32'(err), 32'd1);
    chk("R4", "still no ack", 32'(ack_in), 32'd0);
    rst = 1'b1; req_in = 1'b0; rail_hi = '0; rail_lo = '0;
    step(); step();
    chk("R1", "reset clears err", 32'(err), 32'd0);
    rst = 1'b0;
    step();
    dual_txn(8'h3E, 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule